// File: doc/BRIEF.md
# External Pin Interrupt Sense Unit

This block watches a set of external interrupt pins and turns activity on each one into an interrupt request for an upstream interrupt controller. Each pin has its own 2-bit sense select, so it can trigger on a low level, a falling edge, a rising edge or both edges. The raw pins first pass through a two-flop synchroniser. Edges are found by comparing the synchronised sample with the one from the cycle before.

When a pin's sense condition is met, its bit in a sticky status register is set. That status bit drives the pin's request output as an active-high level until software acknowledges it. Software reaches the block over a simple 32-bit register bus with an address, a write enable, write data and registered read data. It acknowledges a pin by writing a 0 to that pin's status bit. A separate non-maskable interrupt line goes straight through the block unchanged. Priority between requests and vectoring are left to the upstream controller.

Top module: `xpin_irq_sense`

## Requirements
- R1: After a synchronous reset, every status bit, every sense bit, every `irq_req` bit and `bus_rdata` read as 0.
- R2: The sense register is at byte address 0x14 and gives each pin two bits, with pin n at bits [2n+1:2n]. A write stores bits [15:0], and a read returns them with bits [31:16] as 0.
- R3: Sense code 0 selects low-level detection. Every cycle a pin's synchronised level is 0, its status bit is set. Clearing the bit while the pin stays low therefore does not keep it clear.
- R4: Sense code 1 selects falling-edge detection. A 1-to-0 change sets the status bit and a 0-to-1 change does not.
- R5: Sense code 2 selects rising-edge detection. A 0-to-1 change sets the status bit and a 1-to-0 change does not.
- R6: Sense code 3 selects detection on both edges. Either change sets the status bit.
- R7: The status register is at byte address 0x10, with bit n belonging to pin n. Writing a 0 to a bit clears it, and writing a 1 leaves it unchanged. A status bit is set only by a detected event, and a detection in the same cycle as a clear takes priority.
- R8: `irq_req[n]` is an active-high level equal to status bit n. A pin change applied between clock edges shows on `irq_req` after exactly the third rising edge (two synchroniser stages plus the status register).
- R9: Reads of any address other than 0x10 and 0x14 return 0, and writes to such addresses change no register.
- R10: `nmi_out` follows `nmi_in` within the same cycle, with no register in the path.
- R11: `bus_rdata` is registered: after a rising edge it holds the contents of the register addressed before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| ext_pin | input | 8 | Asynchronous external interrupt pins |
| irq_req | output | 8 | Active-high request per pin toward the upstream controller |
| nmi_in | input | 1 | Non-maskable interrupt input |
| nmi_out | output | 1 | Non-maskable interrupt, passed through |

## Verification
A pin change driven at a falling clock edge takes three rising edges to appear on `irq_req`. The bench therefore samples the request just before and just after that third edge. Read data arrives one edge after the address, so each read drives the address at a falling edge and samples `bus_rdata` at the next falling edge. Each table vector sets up its sense code and starting level, waits four cycles and clears the status. It then applies the final level and waits four more cycles, so the pipeline has settled before the status is read back. The same-cycle priority of a detection over a clear is checked by clearing while a low-level pin is held low.

// File: rtl/xpin_irq_pkg.sv
package xpin_irq_pkg;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'd0,
    SENSE_FALL = 2'd1,
    SENSE_RISE = 2'd2,
    SENSE_BOTH = 2'd3
  } sense_e;

  // Event for one pin from the current and previous synchronised samples.
  function automatic logic pin_event(input sense_e mode, input logic cur, input logic prev);
    case (mode)
      SENSE_LOW:  return ~cur;
      SENSE_FALL: return prev & ~cur;
      SENSE_RISE: return ~prev & cur;
      default:    return prev ^ cur;
    endcase
  endfunction

endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
  parameter int W = 8,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= {W{RST_LEVEL}};
      q      <= {W{RST_LEVEL}};
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
  import xpin_irq_pkg::*;
#(
  parameter int N_PINS = 8,
  parameter logic RST_LEVEL = 1'b1,
  localparam int SENSE_W = 2 * N_PINS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_PINS-1:0]  cur,
  input  logic [SENSE_W-1:0] sense,
  output logic [N_PINS-1:0]  prev,
  output logic [N_PINS-1:0]  det
);
  always_ff @(posedge clk) begin
    if (rst) prev <= {N_PINS{RST_LEVEL}};
    else     prev <= cur;
  end

  for (genvar i = 0; i < N_PINS; i++) begin : g_pin
    always_comb det[i] = pin_event(sense_e'(sense[2*i +: 2]), cur[i], prev[i]);
  end
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SENSE_ADDR  = 8'h14,
  localparam int SENSE_W = 2 * N_PINS
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               we,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [N_PINS-1:0]  det,
  output logic [N_PINS-1:0]  status_q,
  output logic [SENSE_W-1:0] sense_q,
  output logic [DATA_W-1:0]  rdata
);
  logic              hit_status, hit_sense;
  logic [N_PINS-1:0] keep_mask;
  logic [DATA_W-1:0] rd_next;

  assign hit_status = (addr == STATUS_ADDR);
  assign hit_sense  = (addr == SENSE_ADDR);
  // A 0 written to a status bit clears it; everything else keeps it.
  assign keep_mask  = (we && hit_status) ? wdata[N_PINS-1:0] : {N_PINS{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      sense_q  <= '0;
    end else begin
      status_q <= (status_q & keep_mask) | det;
      if (we && hit_sense) sense_q <= wdata[SENSE_W-1:0];
    end
  end

  always_comb begin
    rd_next = '0;
    if (hit_status)     rd_next[N_PINS-1:0]  = status_q;
    else if (hit_sense) rd_next[SENSE_W-1:0] = sense_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end

  if (DATA_W > SENSE_W) begin : g_unused
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^wdata[DATA_W-1:SENSE_W];
  end

  // R7: a status bit rises only after a detected event
  a_r7_set_needs_event: assert property (@(posedge clk) disable iff (rst)
    ((status_q & ~$past(status_q) & ~$past(det)) == '0));
  // R7: a status bit falls only after a zero was written to it
  a_r7_clear_needs_zero: assert property (@(posedge clk) disable iff (rst)
    ((($past(status_q) & ~status_q) & $past(keep_mask)) == '0));
  // R2: sense write lands in the register
  a_r2_sense_store: assert property (@(posedge clk) disable iff (rst)
    (we && hit_sense) |=> (sense_q == $past(wdata[SENSE_W-1:0])));
  // R9: unmapped writes leave the sense register alone
  a_r9_unmapped_write: assert property (@(posedge clk) disable iff (rst)
    (we && !hit_status && !hit_sense) |=> $stable(sense_q));
  // R11: read data reflects the status addressed before the edge
  a_r11_rdata_status: assert property (@(posedge clk) disable iff (rst)
    hit_status |=> (rdata[N_PINS-1:0] == $past(status_q)));
  // R9: unmapped reads return zero
  a_r9_unmapped_read: assert property (@(posedge clk) disable iff (rst)
    (!hit_status && !hit_sense) |=> (rdata == '0));
endmodule

// File: rtl/xpin_irq_sense.sv
module xpin_irq_sense #(
  parameter int N_PINS = 8,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 8'h10,
  parameter logic [ADDR_W-1:0] SENSE_ADDR  = 8'h14,
  parameter logic PIN_IDLE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_PINS-1:0] ext_pin,
  output logic [N_PINS-1:0] irq_req,
  input  logic              nmi_in,
  output logic              nmi_out
);
  localparam int SENSE_W = 2 * N_PINS;

  logic [N_PINS-1:0]  pin_s, pin_prev, pin_det, status;
  logic [SENSE_W-1:0] sense;

  xpin_sync #(.W(N_PINS), .RST_LEVEL(PIN_IDLE)) u_sync (
    .clk(clk), .rst(rst), .d(ext_pin), .q(pin_s)
  );

  xpin_detect #(.N_PINS(N_PINS), .RST_LEVEL(PIN_IDLE)) u_detect (
    .clk(clk), .rst(rst), .cur(pin_s), .sense(sense),
    .prev(pin_prev), .det(pin_det)
  );

  xpin_regs #(
    .N_PINS(N_PINS), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .STATUS_ADDR(STATUS_ADDR), .SENSE_ADDR(SENSE_ADDR)
  ) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .det(pin_det), .status_q(status), .sense_q(sense), .rdata(bus_rdata)
  );

  assign irq_req = status;
  assign nmi_out = nmi_in;

  for (genvar i = 0; i < N_PINS; i++) begin : g_chk
    // R3: low level raises the request on the next edge
    a_r3_level_low: assert property (@(posedge clk) disable iff (rst)
      (sense[2*i +: 2] == 2'd0 && !pin_s[i]) |=> irq_req[i]);
    // R4: falling edge raises the request
    a_r4_falling: assert property (@(posedge clk) disable iff (rst)
      (sense[2*i +: 2] == 2'd1 && pin_prev[i] && !pin_s[i]) |=> irq_req[i]);
    // R5: rising edge raises the request
    a_r5_rising: assert property (@(posedge clk) disable iff (rst)
      (sense[2*i +: 2] == 2'd2 && !pin_prev[i] && pin_s[i]) |=> irq_req[i]);
    // R6: any edge raises the request
    a_r6_both: assert property (@(posedge clk) disable iff (rst)
      (sense[2*i +: 2] == 2'd3 && (pin_prev[i] != pin_s[i])) |=> irq_req[i]);
  end
endmodule

// File: tb/xpin_irq_sense_test.sv
module xpin_irq_sense_test;
  localparam int N = 8;
  localparam logic [7:0] A_STAT  = 8'h10;
  localparam logic [7:0] A_SENSE = 8'h14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  bus_addr = 8'h00;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [N-1:0] ext_pin = '1;
  logic [N-1:0] irq_req;
  logic        nmi_in = 1'b0;
  logic        nmi_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  xpin_irq_sense uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ext_pin(ext_pin),
    .irq_req(irq_req), .nmi_in(nmi_in), .nmi_out(nmi_out)
  );

  // Vector: {sense code[1:0], start level, end level}
  localparam logic [3:0] VEC [16] = '{
    4'b00_1_1, 4'b00_1_0, 4'b00_0_1, 4'b00_0_0,
    4'b01_1_1, 4'b01_1_0, 4'b01_0_1, 4'b01_0_0,
    4'b10_1_1, 4'b10_1_0, 4'b10_0_1, 4'b10_0_0,
    4'b11_1_1, 4'b11_1_0, 4'b11_0_1, 4'b11_0_0
  };

  function automatic logic expect_evt(input logic [1:0] m, input logic s, input logic e);
    case (m)
      2'd0: return !s || !e;   // low level reasserts across the clear
      2'd1: return s && !e;
      2'd2: return !s && e;
      default: return s != e;
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    wait_cyc(3);
    rst = 1'b0;
    wait_cyc(1);

    // R1: reset state
    check("R1 irq_req", {24'b0, irq_req}, 32'h0);
    check("R1 rdata", bus_rdata, 32'h0);
    bus_read(A_STAT, rd);  check("R1 status", rd, 32'h0);
    bus_read(A_SENSE, rd); check("R1 sense", rd, 32'h0);

    // R10: NMI feed-through
    nmi_in = 1'b1; #1; check("R10 nmi high", {31'b0, nmi_out}, 32'h1);
    nmi_in = 1'b0; #1; check("R10 nmi low", {31'b0, nmi_out}, 32'h0);

    // R2: sense layout and read-back width
    bus_write(A_SENSE, 32'hFFFF_E4A1);
    bus_read(A_SENSE, rd); check("R2 sense readback", rd, 32'h0000_E4A1);

    // Table walk: R3 R4 R5 R6 per pin
    for (int i = 0; i < 16; i++) begin
      int p = i % N;
      logic [1:0] m = VEC[i][3:2];
      logic s = VEC[i][1];
      logic e = VEC[i][0];
      logic [31:0] exp = {31'b0, expect_evt(m, s, e)} << p;
      ext_pin = '1;
      bus_write(A_SENSE, 32'(m) << (2 * p));
      wait_cyc(4);
      ext_pin[p] = s;
      wait_cyc(4);
      bus_write(A_STAT, 32'h0);
      ext_pin[p] = e;
      wait_cyc(4);
      bus_read(A_STAT, rd);
      check($sformatf("R3-6 vec%0d mode%0d R%0d status", i, m, 3 + m), rd, exp);
      check("R8 irq_req matches status", {24'b0, irq_req}, exp);
    end
    ext_pin = '1;
    bus_write(A_SENSE, 32'h0);
    wait_cyc(4);
    bus_write(A_STAT, 32'h0);

    // R8: three-edge latency, rising mode on pin 5
    bus_write(A_SENSE, 32'h2 << 10);
    ext_pin[5] = 1'b0;
    wait_cyc(4);
    bus_write(A_STAT, 32'h0);
    ext_pin[5] = 1'b1;           // driven at a falling edge
    wait_cyc(2);
    check("R8 not yet after two edges", {24'b0, irq_req}, 32'h0);
    wait_cyc(1);
    check("R8 set after third edge", {24'b0, irq_req}, 32'h20);

    // R7: write-zero-to-clear, falling mode everywhere
    bus_write(A_SENSE, 32'h5555);
    bus_write(A_STAT, 32'h0);
    ext_pin[0] = 1'b0; ext_pin[3] = 1'b0;
    wait_cyc(4);
    bus_read(A_STAT, rd); check("R7 two events", rd, 32'h09);
    bus_write(A_STAT, 32'hFFFF_FFF7);
    bus_read(A_STAT, rd); check("R7 zero clears bit3 only", rd, 32'h01);
    bus_write(A_STAT, 32'hFFFF_FFFF);
    bus_read(A_STAT, rd); check("R7 ones keep", rd, 32'h01);
    check("R7 irq_req after clear", {24'b0, irq_req}, 32'h01);

    // R9: unmapped addresses
    bus_write(8'h20, 32'h0);
    bus_write(8'h18, 32'h0);
    bus_read(8'h20, rd); check("R9 unmapped read 0x20", rd, 32'h0);
    bus_read(8'h18, rd); check("R9 unmapped read 0x18", rd, 32'h0);
    bus_read(A_SENSE, rd); check("R9 sense untouched", rd, 32'h5555);
    bus_read(A_STAT, rd);  check("R9 status untouched", rd, 32'h01);

    // R3: clear while pin 0 held low in level mode does not stick
    bus_write(A_SENSE, 32'h0);
    bus_write(A_STAT, 32'h0);
    bus_read(A_STAT, rd); check("R3 reasserted after clear", rd, 32'h09);

    // R11: registered read data follows the previous address
    @(negedge clk); bus_addr = 8'h24;
    @(negedge clk); bus_addr = A_SENSE;
    check("R11 rdata before edge", bus_rdata, 32'h0);
    @(negedge clk);
    check("R11 rdata after edge", bus_rdata, 32'h0);
    bus_write(A_SENSE, 32'h3);
    @(negedge clk);
    check("R11 rdata new sense", bus_rdata, 32'h3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule